// File: doc/BRIEF.md
# Register-Access SPI Slave

This block is a serial slave that lets a host processor read and write a bank of 16-bit registers and packet buffers over a four-wire SPI link. The host frames every transaction by pulling an active-low select low. The first byte it shifts in is a header: a direction flag, a reserved bit and a 6-bit resource address. Every later pair of bytes moves one 16-bit word, either into the block from MOSI or out of it on MISO. The link uses SPI mode 0: the clock idles low, the block samples on the rising edge and changes MISO on the falling edge, and bytes travel most significant bit first.

On the register side the block presents an address, a one-cycle write strobe with a data word, and a one-cycle read strobe. The bank must return read data combinationally in the cycle the read strobe is high. A write is issued only after a complete byte pair has arrived. A read word is fetched as soon as the header completes and again after each pair has been shifted out. Every pair in a transaction targets the header's address, so a host can stream a packet buffer through a single location. A select that rises part-way through a word, or a header whose reserved bit is set, causes no register access. While the select is high, a control input chooses between releasing MISO (high impedance) and driving it low.

The SPI pins are taken to be synchronous to the block clock `clk`, and each SPI clock phase must last at least three `clk` cycles. Pin synchronisation belongs to the surrounding logic.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is asserted and after it is released with the select high, both strobes are low and MISO is idle as R8 defines.
- R2: MOSI is sampled on rising SCLK edges while the select is low, most significant bit first, and every eight rising edges form one byte.
- R3: In the header byte, bit 7 = 1 means read and 0 means write, bits 5:0 are the address, and bit 6 is reserved and must be 0. A header with bit 6 = 1 produces no write or read strobe for the rest of the transaction, and MISO stays 0.
- R4: In a write transaction, each complete pair of payload bytes produces exactly one single-cycle write strobe. The data word is {first byte, second byte} and the address is the one in the header.
- R5: In a read transaction, one read strobe is issued when the header completes. The fetched word is shifted out high byte first, MSB first, and MISO changes only after falling SCLK edges.
- R6: Every byte pair in one transaction uses the header address. A write burst of N pairs produces N strobes in order. A read of N pairs issues N+1 read strobes: one at the header and one after each pair.
- R7: A select rise after an odd number of payload bytes, or before any payload byte, discards the partial word and issues no write strobe for it. Words already completed in that transaction are still written.
- R8: While the select is high, MISO output enable equals NOT of the idle-release control and MISO data is 0. While the select is low, the output enable is 1.
- R9: During a write transaction, MISO reads as 0 in every payload bit.
- R10: A select rise in the middle of a byte discards the partial bits, and the next transaction starts again with a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad |
| miso_hiz_en | input | 1 | 1: release MISO while idle; 0: drive it low |
| reg_addr | output | ADDR_W | Register address taken from the header |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | WORD_W | Write data word |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rdata | input | WORD_W | Read data, valid in the cycle the read strobe is high |

## Verification
The bench targets the byte-pair boundary. It aborts after one payload byte, after the header alone and after three payload bytes. A design that strobed on every byte, or that flushed a half word when the select rose, would corrupt the target register. A header with the reserved bit set is sent in both directions: a design that decoded only bit 7 would write the register or drive read data. Read bursts check the high-byte-first order and the N+1 fetch count, which would break if the word were loaded late or fetched only once. A select raised in the middle of a byte is followed by a normal write, which shows whether stale bit counts carry over into the next header.

// File: rtl/spi_reg_pkg.sv
// Shared types and header field positions for the register-access SPI slave.
// Assumes an 8-bit header: direction flag in the top bit, reserved bit below it.
package spi_reg_pkg;
    localparam int HDR_RW_BIT  = 7;
    localparam int HDR_RSV_BIT = 6;

    typedef enum logic [1:0] {
        PH_HEADER = 2'd0,
        PH_WRITE  = 2'd1,
        PH_READ   = 2'd2,
        PH_REJECT = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_pin_sampler.sv
// Turns the SPI clock and select pins into single-cycle edge pulses in the clk domain.
// Assumes the pins are already synchronous to clk and each SCLK phase spans at least 3 clk cycles.
module spi_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    output logic sel,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic sclk_q;

    // Remember the previous SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= spi_sclk;
    end

    // Edges count only while the transaction select is active.
    always_comb begin
        sel       = ~spi_cs_n;
        sclk_rise = sel &  spi_sclk & ~sclk_q;
        sclk_fall = sel & ~spi_sclk &  sclk_q;
    end
endmodule

// File: rtl/spi_byte_rx.sv
// Collects MOSI bits, MSB first, on rising SCLK and flags each completed byte.
// Assumes sel low clears any partial byte, so each transaction starts byte-aligned.
module spi_byte_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              mosi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shift_q;

    // Shift in one bit per rising edge; drop the partial byte when select ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else if (sclk_rise) begin
            shift_q <= {shift_q[BYTE_W-3:0], mosi};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // The byte completes on its last rising edge, including the live MOSI bit.
    always_comb begin
        byte_done = sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
        byte_val  = {shift_q, mosi};
    end
endmodule

// File: rtl/spi_txn_ctrl.sv
// Decodes the header, pairs payload bytes into words and issues register strobes.
// Assumes WORD_W is two bytes; every pair in a transaction uses the header address.
module spi_txn_ctrl
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_rd_en
);
    phase_e            phase;
    logic              have_hi;
    logic [BYTE_W-1:0] hi_byte;

    // Transaction sequencing: header decode, then word assembly or read pacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_HEADER;
            have_hi   <= 1'b0;
            hi_byte   <= '0;
            reg_addr  <= '0;
            reg_wr_en <= 1'b0;
            reg_wdata <= '0;
            reg_rd_en <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;
            if (!sel) begin
                phase   <= PH_HEADER;
                have_hi <= 1'b0;
            end else if (byte_done) begin
                case (phase)
                    PH_HEADER: begin
                        reg_addr <= byte_val[ADDR_W-1:0];
                        if (byte_val[HDR_RSV_BIT]) begin
                            phase <= PH_REJECT;
                        end else if (byte_val[HDR_RW_BIT]) begin
                            phase     <= PH_READ;
                            reg_rd_en <= 1'b1;
                        end else begin
                            phase <= PH_WRITE;
                        end
                    end
                    PH_WRITE: begin
                        if (have_hi) begin
                            reg_wr_en <= 1'b1;
                            reg_wdata <= {hi_byte, byte_val};
                            have_hi   <= 1'b0;
                        end else begin
                            hi_byte <= byte_val;
                            have_hi <= 1'b1;
                        end
                    end
                    PH_READ: begin
                        reg_rd_en <= have_hi;
                        have_hi   <= ~have_hi;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_miso_tx.sv
// Shifts a fetched word out on MISO, changing only after falling SCLK edges.
// Assumes load arrives before the next falling edge; idle drive follows miso_hiz_en.
module spi_miso_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              sclk_fall,
    input  logic              miso_hiz_en,
    output logic              miso_o,
    output logic              miso_oe
);
    logic [WORD_W-1:0] tx_q;
    logic              miso_q;

    // Load a fetched word, or present its next bit on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (sclk_fall) begin
            miso_q <= tx_q[WORD_W-1];
            tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    // Pad control: driven during a transaction, released or held low when idle.
    always_comb begin
        miso_oe = sel | ~miso_hiz_en;
        miso_o  = sel & miso_q;
    end
endmodule

// File: rtl/spi_reg_slave.sv
// Top of the register-access SPI slave: mode 0, MSB first, header plus 16-bit words.
// Assumes reg_rdata is valid combinationally while reg_rd_en is high.
module spi_reg_slave #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso_o,
    output logic              spi_miso_oe,
    input  logic              miso_hiz_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    input  logic [WORD_W-1:0] reg_rdata
);
    localparam int BYTE_W = WORD_W / 2;

    logic              sel;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;

    spi_pin_sampler u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    spi_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .mosi      (spi_mosi),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    spi_txn_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rd_en (reg_rd_en)
    );

    spi_miso_tx #(.WORD_W(WORD_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .load        (reg_rd_en),
        .load_word   (reg_rdata),
        .sclk_fall   (sclk_fall),
        .miso_hiz_en (miso_hiz_en),
        .miso_o      (spi_miso_o),
        .miso_oe     (spi_miso_oe)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Protocol checker for the register-access SPI slave, attached by bind.
// Assumes the same clock and synchronous active-low reset as the block.
module spi_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_sclk,
    input logic spi_cs_n,
    input logic spi_miso_o,
    input logic spi_miso_oe,
    input logic miso_hiz_en,
    input logic reg_wr_en,
    input logic reg_rd_en
);
    // R4: a write strobe only follows a cycle with the select active.
    p_wr_inside_txn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !$past(spi_cs_n));

    // R4: each write strobe lasts one cycle.
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R5: each read strobe lasts one cycle.
    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    // R3: a transaction moves data in one direction only.
    p_one_direction_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R8: idle pad state follows the release control.
    p_idle_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_miso_oe == !miso_hiz_en) && !spi_miso_o);

    // R8: the pad is driven while a transaction is open.
    p_sel_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> spi_miso_oe);

    // R5: inside a transaction MISO moves only after a falling SCLK edge.
    p_miso_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !$past(spi_cs_n) && !(!$past(spi_sclk) && $past(spi_sclk, 2)))
        |-> $stable(spi_miso_o));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_o  (spi_miso_o),
    .spi_miso_oe (spi_miso_oe),
    .miso_hiz_en (miso_hiz_en),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en)
);

// File: tb/spi_reg_slave_tb.sv
// Directed bench: the bench acts as SPI host and as the register bank.
module spi_reg_slave_tb_top;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        miso_hiz_en = 1'b1;
    logic        spi_miso_o;
    logic        spi_miso_oe;
    logic [5:0]  reg_addr;
    logic        reg_wr_en;
    logic [15:0] reg_wdata;
    logic        reg_rd_en;
    logic [15:0] reg_rdata;

    logic [15:0] regs [64];
    logic [15:0] wlog [8];
    int          wr_count = 0;
    int          rd_count = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    spi_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso_o(spi_miso_o), .spi_miso_oe(spi_miso_oe),
        .miso_hiz_en(miso_hiz_en), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            regs[reg_addr] <= reg_wdata;
            wlog[wr_count[2:0]] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
        if (reg_rd_en) rd_count <= rd_count + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_begin();
        @(negedge clk); spi_cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic spi_end();
        wait_clk(HALF); spi_cs_n = 1'b1; wait_clk(6);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            wait_clk(HALF);
            rx[i] = spi_miso_o;
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic t_reset();
        chk("R1 wr strobe", 32'(reg_wr_en), 0);
        chk("R1 rd strobe", 32'(reg_rd_en), 0);
        chk("R1 idle oe", 32'(spi_miso_oe), 0);
    endtask

    task automatic t_write_single();
        logic [7:0] r0, r1;
        int c0 = wr_count;
        spi_begin();
        spi_byte(8'h05, r0);
        spi_byte(8'hA5, r0);
        spi_byte(8'h5A, r1);
        spi_end();
        chk("R4 write data", 32'(regs[5]), 32'hA55A);
        chk("R4 one strobe", 32'(wr_count - c0), 1);
        chk("R9 miso low during write", 32'({r0, r1}), 0);
    endtask

    task automatic t_write_burst();
        logic [7:0] r;
        int c0 = wr_count;
        spi_begin();
        spi_byte(8'h3F, r);
        spi_byte(8'h12, r); spi_byte(8'h34, r);
        spi_byte(8'h56, r); spi_byte(8'h78, r);
        spi_byte(8'h9A, r); spi_byte(8'hBC, r);
        spi_end();
        chk("R6 burst strobes", 32'(wr_count - c0), 3);
        chk("R6 burst word0", 32'(wlog[c0[2:0]]), 32'h1234);
        chk("R6 burst word1", 32'(wlog[3'(c0 + 1)]), 32'h5678);
        chk("R6 burst final", 32'(regs[6'h3F]), 32'h9ABC);
    endtask

    task automatic t_read_single();
        logic [7:0] h, hi, lo;
        int c0 = rd_count;
        regs[6'h12] = 16'hC3A5;
        spi_begin();
        spi_byte(8'h92, h);
        spi_byte(8'h00, hi);
        spi_byte(8'h00, lo);
        spi_end();
        chk("R5 read high byte", 32'(hi), 32'hC3);
        chk("R5 read low byte", 32'(lo), 32'hA5);
        chk("R5 header miso 0", 32'(h), 0);
        chk("R6 read strobes 1 pair", 32'(rd_count - c0), 2);
    endtask

    task automatic t_read_burst();
        logic [7:0] r, b0, b1, b2, b3;
        int c0 = rd_count;
        regs[6'h20] = 16'h0FF0;
        spi_begin();
        spi_byte(8'hA0, r);
        spi_byte(8'h00, b0); spi_byte(8'h00, b1);
        spi_byte(8'h00, b2); spi_byte(8'h00, b3);
        spi_end();
        chk("R6 read burst word0", 32'({b0, b1}), 32'h0FF0);
        chk("R6 read burst word1", 32'({b2, b3}), 32'h0FF0);
        chk("R6 read strobes 2 pairs", 32'(rd_count - c0), 3);
    endtask

    task automatic t_odd_abort();
        logic [7:0] r;
        int c0;
        regs[7] = 16'h1111;
        c0 = wr_count;
        spi_begin(); spi_byte(8'h07, r); spi_end();
        chk("R7 header only", 32'(wr_count - c0), 0);
        spi_begin(); spi_byte(8'h07, r); spi_byte(8'hEE, r); spi_end();
        chk("R7 odd byte strobes", 32'(wr_count - c0), 0);
        chk("R7 odd byte reg kept", 32'(regs[7]), 32'h1111);
        spi_begin(); spi_byte(8'h07, r);
        spi_byte(8'h22, r); spi_byte(8'h33, r); spi_byte(8'h44, r);
        spi_end();
        chk("R7 three bytes strobes", 32'(wr_count - c0), 1);
        chk("R7 three bytes reg", 32'(regs[7]), 32'h2233);
    endtask

    task automatic t_reserved();
        logic [7:0] r, b0, b1;
        int w0 = wr_count;
        int d0 = rd_count;
        regs[5] = 16'h7777;
        spi_begin(); spi_byte(8'h45, r); spi_byte(8'h01, r); spi_byte(8'h02, r); spi_end();
        chk("R3 reserved write strobes", 32'(wr_count - w0), 0);
        chk("R3 reserved write reg", 32'(regs[5]), 32'h7777);
        spi_begin(); spi_byte(8'hC5, r); spi_byte(8'h00, b0); spi_byte(8'h00, b1); spi_end();
        chk("R3 reserved read strobes", 32'(rd_count - d0), 0);
        chk("R3 reserved read miso", 32'({b0, b1}), 0);
    endtask

    task automatic t_idle();
        miso_hiz_en = 1'b0; wait_clk(1);
        chk("R8 driven-low oe", 32'(spi_miso_oe), 1);
        chk("R8 driven-low data", 32'(spi_miso_o), 0);
        miso_hiz_en = 1'b1; wait_clk(1);
        chk("R8 released oe", 32'(spi_miso_oe), 0);
        spi_cs_n = 1'b0; wait_clk(1);
        chk("R8 selected oe", 32'(spi_miso_oe), 1);
        spi_cs_n = 1'b1; wait_clk(4);
    endtask

    task automatic t_midbyte();
        logic [7:0] r;
        int c0 = wr_count;
        spi_begin(); spi_bits(8'hFF, 3, r); spi_end();
        spi_begin(); spi_byte(8'h09, r); spi_byte(8'hBE, r); spi_byte(8'hEF, r); spi_end();
        chk("R10 restart strobes", 32'(wr_count - c0), 1);
        chk("R10 restart data", 32'(regs[9]), 32'hBEEF);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) regs[i] = 16'h0000;
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_write_single();   // R2 R4 R9
        t_write_burst();    // R6
        t_read_single();    // R5
        t_read_burst();     // R6
        t_odd_abort();      // R7
        t_reserved();       // R3
        t_idle();           // R8
        t_midbyte();        // R10
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule